// File: doc/BRIEF.md
# I2C bit-transfer clock engine

This block moves one short serial word across a two-wire open-drain bus in Standard mode. A host first writes a small configuration word that sets how many data bits go out (one to eight), whether an extra clock pulse is added for the acknowledge bit, and a clock-select code. A start strobe then begins the transfer. The engine drives the clock line low and releases it for equal half periods. Each half period lasts PRESCALE/2 × (2^n + 35) system cycles, where n = 4 + clock-select code. With the default PRESCALE of 4 this gives an SCL rate of (f_sys/4)/(2^n + 35).

Data leaves most significant bit first, starting from bit 7 of the transmit byte. Each bit is placed on the data line while the clock is held low. The engine samples the data line at the moment it releases the clock, so the bits that come back land in a receive byte. In acknowledge mode the engine lets go of the data line during the extra pulse and records the level a receiver drove there.

START and STOP framing, arbitration and address matching are left to an enclosing controller. A software-reset input aborts a transfer through a short fixed sequence, and a monitor output shows when the engine is usable.

Top module: `i2c_bitclk_engine`

## Requirements
- R1: Clock-select code k (0..6) gives SCL low and high half periods of exactly 2·(2^(4+k)+35) system cycles each; code 0 gives 102 and code 1 gives 134.
- R2: Configuration word bits [7:5] hold the bit count: 000 means 8 data bits and 001..111 mean 1..7. Data goes out MSB-first from tx_byte bit 7. Each sampled bit shifts into rx_byte from the LSB end, so after n bits rx_byte holds them in bits [n-1:0] and its upper bits are 0.
- R3: With configuration bit 4 set, one more SCL pulse follows the data bits, so the total pulse count is bits+1. During that pulse sda_oe is 0, and the SDA level sampled at its clock release is stored in rx_ack. With bit 4 clear, the pulse count equals the bit count and rx_ack reads 1.
- R4: With clock-select code 111 (bits [2:0]), a start is ignored: busy stays 0 and scl_oe stays 0.
- R5: During a transfer, sda_oe changes only at edges where scl_oe is 1 (clock held low). SDA is sampled at the edge where scl_oe goes from 1 to 0.
- R6: A soft_rst pulse starts a 4-cycle software reset. For the 4 cycles after the pulse, swr_mon reads 0. From the second of those cycles onward, busy, scl_oe and sda_oe are 0 and no done pulse is produced. After the sequence, swr_mon returns to 1 and a new transfer runs normally.
- R7: While if_en is 0, swr_mon reads 0 and a start is ignored.
- R8: ctl_rdata = {bit count[7:5], ack mode[4], 1, clock select[2:0]}. Bit 3 always reads 1, and after reset ctl_rdata is 8'h08.
- R9: done is a single-cycle pulse in the cycle after the last high half ends. busy is 0 in that cycle. While idle, scl_oe and sda_oe are 0.
- R10: A start strobe while busy is 1 has no effect on the running transfer's pulse count or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_en | input | 1 | Interface enable |
| ctl_we | input | 1 | Configuration word write strobe |
| ctl_wdata | input | 8 | Configuration word write data |
| ctl_rdata | output | 8 | Configuration word readback |
| start | input | 1 | Transfer start strobe |
| tx_byte | input | 8 | Byte to transmit, bit 7 first |
| rx_byte | output | 8 | Bits sampled during the last transfer |
| rx_ack | output | 1 | SDA level sampled in the acknowledge pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA line level |
| soft_rst | input | 1 | Software reset request pulse |
| swr_mon | output | 1 | 1 when enabled and not in software reset |

## Verification
Transfers are tried at every interesting bit-count code: full byte (000), one bit, three bits and seven bits. These cases tell apart the 000 = 8 mapping, the MSB-first order and where short words land in rx_byte. Each count is run with and without acknowledge mode, and the receiver model either stays silent or pulls SDA low on chosen pulses. This separates data loopback, ack capture and ack release, and the measured pulse count shows whether the extra pulse is added. Two clock codes are measured to separate the 2^n term from the constant offset. A software reset in the middle of a word, a start while busy, a reserved clock code and a disabled interface each check that nothing leaks onto the bus.

// File: rtl/ibe_pkg.sv
package ibe_pkg;

  typedef struct packed {
    logic [2:0] bitcode;
    logic       ackx;
    logic [2:0] clksel;
  } ibe_cfg_t;

  localparam logic [2:0] CLK_RESERVED = 3'b111;

  // data bits carried by a word for a given count code (000 stands for 8)
  function automatic int unsigned data_bits(input logic [2:0] code);
    return (code == 3'd0) ? 32'd8 : 32'(code);
  endfunction

  // SCL pulses per word, including the optional acknowledge pulse
  function automatic int unsigned pulse_total(input logic [2:0] code, input logic ackx);
    return data_bits(code) + (ackx ? 32'd1 : 32'd0);
  endfunction

  // system cycles per SCL half period
  function automatic int unsigned half_cycles(input logic [2:0] sel,
                                              input int unsigned prescale,
                                              input int unsigned offset,
                                              input int unsigned nmin);
    int unsigned n;
    n = nmin + 32'(sel);
    return (prescale * ((32'd1 << n) + offset)) / 32'd2;
  endfunction

endpackage

// File: rtl/ibe_ctrl_reg.sv
module ibe_ctrl_reg
  import ibe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ibe_cfg_t   cfg,
  output logic [7:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.bitcode <= wdata[7:5];
      cfg.ackx    <= wdata[4];
      cfg.clksel  <= wdata[2:0];
    end
  end

  assign rdata = {cfg.bitcode, cfg.ackx, 1'b1, cfg.clksel};
endmodule

// File: rtl/ibe_swreset.sv
module ibe_swreset #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (req && cnt == '0)  cnt <= CW'(LEN);
    else if (cnt != '0)         cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/ibe_scl_timer.sv
module ibe_scl_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == '0);
endmodule

// File: rtl/ibe_bit_shifter.sv
module ibe_bit_shifter
  import ibe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       go,
  input  logic [2:0] bitcode,
  input  logic       ackx,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       sda_in,
  output logic       busy,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       rx_ack,
  output logic       done,
  output logic       sample_evt
);
  logic       phase_high;
  logic [3:0] idx, total, nbits;
  logic [7:0] tx_sh;
  logic [3:0] idx_nx;

  assign idx_nx     = idx + 4'd1;
  assign sample_evt = busy && tick && !phase_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase_high <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      idx <= '0; total <= '0; nbits <= '0; tx_sh <= '0;
      rx_byte <= '0; rx_ack <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0; phase_high <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
        idx <= '0;
      end else if (go) begin
        busy       <= 1'b1;
        phase_high <= 1'b0;
        idx        <= '0;
        nbits      <= 4'(data_bits(bitcode));
        total      <= 4'(pulse_total(bitcode, ackx));
        tx_sh      <= {tx_byte[6:0], 1'b0};
        sda_oe     <= ~tx_byte[7];
        scl_oe     <= 1'b1;
        rx_byte    <= '0;
        rx_ack     <= 1'b1;
      end else if (busy && tick) begin
        if (!phase_high) begin
          phase_high <= 1'b1;
          scl_oe     <= 1'b0;
          if (idx < nbits) rx_byte <= {rx_byte[6:0], sda_in};
          else             rx_ack  <= sda_in;
        end else if (idx_nx == total) begin
          busy <= 1'b0; phase_high <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
          done <= 1'b1;
        end else begin
          idx        <= idx_nx;
          phase_high <= 1'b0;
          scl_oe     <= 1'b1;
          if (idx_nx < nbits) begin
            sda_oe <= ~tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_bitclk_engine.sv
module i2c_bitclk_engine
  import ibe_pkg::*;
#(
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned DIV_OFFSET = 35,
  parameter int unsigned N_MIN      = 4,
  parameter int unsigned SWR_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       rx_ack,
  output logic       busy,
  output logic       done,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in,
  input  logic       soft_rst,
  output logic       swr_mon
);
  localparam int unsigned HALF_MAX = PRESCALE * ((32'd1 << (N_MIN + 6)) + DIV_OFFSET) / 2;
  localparam int unsigned CNT_W    = $clog2(HALF_MAX + 1);

  ibe_cfg_t         cfg;
  logic             swr_active;
  logic             start_ok;
  logic             phase_tick;
  logic             sample_evt;
  logic [2:0]       clk_code;
  logic [CNT_W-1:0] half_now, half_q, load_val;

  ibe_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .cfg(cfg), .rdata(ctl_rdata)
  );

  ibe_swreset #(.LEN(SWR_LEN)) u_swr (
    .clk(clk), .rst_n(rst_n), .req(soft_rst), .active(swr_active)
  );

  assign clk_code = cfg.clksel;
  assign start_ok = start && !busy && if_en && !swr_active && (clk_code != CLK_RESERVED);
  assign half_now = CNT_W'(half_cycles(clk_code, PRESCALE, DIV_OFFSET, N_MIN) - 32'd1);
  assign load_val = start_ok ? half_now : half_q;
  assign swr_mon  = if_en && !swr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        half_q <= '0;
    else if (start_ok) half_q <= half_now;
  end

  ibe_scl_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(swr_active), .run(busy),
    .load(start_ok || phase_tick), .load_val(load_val), .expire(phase_tick)
  );

  ibe_bit_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .abort(swr_active), .go(start_ok),
    .bitcode(cfg.bitcode), .ackx(cfg.ackx), .tx_byte(tx_byte),
    .tick(phase_tick), .sda_in(sda_in),
    .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .rx_ack(rx_ack), .done(done), .sample_evt(sample_evt)
  );
endmodule

// File: rtl/ibe_checker.sv
module ibe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       soft_rst,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       swr_active,
  input logic       swr_mon,
  input logic       phase_tick,
  input logic       sample_evt,
  input logic [2:0] clk_code
);
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  assert_sda_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sda_oe != $past(sda_oe))) |-> scl_oe);

  assert_sample_at_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> !scl_oe);

  assert_scl_moves_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (scl_oe != $past(scl_oe))) |-> $past(phase_tick));

  assert_swrst_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swr_active |=> (!busy && !scl_oe && !sda_oe && !done));

  assert_swrst_monitor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !swr_active) |=> !swr_mon);

  assert_reserved_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && clk_code == 3'b111) |=> !busy);
endmodule

bind i2c_bitclk_engine ibe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .soft_rst(soft_rst),
  .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .swr_active(swr_active), .swr_mon(swr_mon), .phase_tick(phase_tick),
  .sample_evt(sample_evt), .clk_code(clk_code)
);

// File: tb/i2c_bitclk_engine_bench.sv
module i2c_bitclk_engine_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, if_en, ctl_we, start, soft_rst, slave_low;
  logic [7:0] ctl_wdata, tx_byte, ctl_rdata, rx_byte;
  logic       rx_ack, busy, done, scl_oe, sda_oe, sda_in, swr_mon;

  assign sda_in = ~(sda_oe | slave_low);

  i2c_bitclk_engine u_i2c_bitclk_engine (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .start(start), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .rx_ack(rx_ack), .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in), .soft_rst(soft_rst), .swr_mon(swr_mon)
  );

  typedef struct { int pulses; logic [7:0] rx; logic rxa; int half; } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  logic [8:0] cur_pat = '0;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts pulses, measures the first high half, models the receiver
  logic prev_scl = 1'b0, prev_busy = 1'b0, prev_sda = 1'b0;
  int falls = 0, hcnt = 0, first_hi = -1, sda_bad = 0;
  always @(negedge clk) begin
    if (busy && !prev_busy) begin falls = 0; hcnt = 0; first_hi = -1; sda_bad = 0; end
    if (busy && prev_busy && sda_oe != prev_sda && !scl_oe) sda_bad++;
    if (busy && !scl_oe) hcnt++;
    if (scl_oe && !prev_scl) begin
      if (hcnt > 0 && first_hi < 0) first_hi = hcnt;
      hcnt = 0;
      slave_low = (falls < 9) ? cur_pat[falls] : 1'b0;
      falls++;
    end
    if (prev_busy && !busy) slave_low = 1'b0;
    if (done) begin
      if (first_hi < 0) first_hi = hcnt;
      check_eq("R9 busy low with done", int'(busy), 0);
      if (sb.size() == 0) check_eq("R6 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check_eq("R2 rx_byte", int'(rx_byte), int'(e.rx));
        check_eq("R3 rx_ack", int'(rx_ack), int'(e.rxa));
        check_eq("R3 pulse count", falls, e.pulses);
        check_eq("R1 half period", first_hi, e.half);
        check_eq("R5 sda moved with scl high", sda_bad, 0);
      end
    end
    prev_scl = scl_oe; prev_busy = busy; prev_sda = sda_oe;
  end

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60000 && (busy || sb.size() != 0); i++) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [2:0] code, input logic ack, input logic [2:0] sel,
                          input logic [7:0] tx, input logic [8:0] pat, input bit poke);
    exp_t e;
    int nb;
    wr_ctl({code, ack, 1'b0, sel});
    nb = (code == 3'd0) ? 8 : int'(code);
    e.rx = '0;
    for (int k = 0; k < nb; k++) e.rx = {e.rx[6:0], tx[7-k] & ~pat[k]};
    e.rxa = ack ? ~pat[nb] : 1'b1;
    e.pulses = nb + (ack ? 1 : 0);
    e.half = 2 * ((1 << (4 + int'(sel))) + 35);
    sb.push_back(e);
    cur_pat = pat; tx_byte = tx;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin  // R10: a second strobe mid-word
      repeat (300) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; if_en = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; start = 1'b0;
    soft_rst = 1'b0; tx_byte = '0; slave_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R8 reset readback", int'(ctl_rdata), 8'h08);
    check_eq("R6 monitor idle", int'(swr_mon), 1);
    check_eq("R9 idle scl", int'(scl_oe), 0);
    check_eq("R9 idle sda", int'(sda_oe), 0);
    check_eq("R9 idle busy", int'(busy), 0);

    wr_ctl(8'b101_1_0_010);
    check_eq("R8 readback layout", int'(ctl_rdata), 8'hBA);

    run_xfer(3'd0, 1'b0, 3'd0, 8'hA5, 9'h000, 1'b0);
    run_xfer(3'd0, 1'b1, 3'd0, 8'h3C, 9'h100, 1'b0);
    run_xfer(3'd3, 1'b1, 3'd0, 8'hFF, 9'h002, 1'b0);
    run_xfer(3'd1, 1'b0, 3'd0, 8'h80, 9'h000, 1'b0);
    run_xfer(3'd7, 1'b1, 3'd1, 8'h5A, 9'h080, 1'b0);
    run_xfer(3'd0, 1'b0, 3'd0, 8'hFF, 9'h0F0, 1'b0);
    run_xfer(3'd0, 1'b1, 3'd0, 8'hC3, 9'h000, 1'b1);

    // R4: reserved clock code
    wr_ctl(8'b000_0_0_111);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    check_eq("R4 busy with reserved code", int'(busy), 0);
    check_eq("R4 scl with reserved code", int'(scl_oe), 0);

    // R7: interface disabled
    wr_ctl(8'b000_0_0_000);
    if_en = 1'b0;
    @(negedge clk);
    check_eq("R7 monitor disabled", int'(swr_mon), 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R7 start ignored", int'(busy), 0);
    if_en = 1'b1;

    // R6: software reset mid-word
    cur_pat = '0; tx_byte = 8'h00;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check_eq("R6 monitor low 1", int'(swr_mon), 0);
    @(negedge clk);
    check_eq("R6 monitor low 2", int'(swr_mon), 0);
    check_eq("R6 busy cleared", int'(busy), 0);
    check_eq("R6 scl released", int'(scl_oe), 0);
    check_eq("R6 sda released", int'(sda_oe), 0);
    @(negedge clk);
    check_eq("R6 monitor low 3", int'(swr_mon), 0);
    @(negedge clk);
    check_eq("R6 monitor low 4", int'(swr_mon), 0);
    @(negedge clk);
    check_eq("R6 monitor back", int'(swr_mon), 1);
    run_xfer(3'd2, 1'b1, 3'd0, 8'h40, 9'h004, 1'b0);

    repeat (5) @(negedge clk);
    check_eq("R2 scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule